// File: doc/BRIEF.md
# Reset Qualifier With Watchdog Reset-Out

This block sits between the reset pin of an 8051-style microcontroller and its core. It watches the already-sampled pin level on every oscillator clock. Only after the pin has stayed high for two whole machine cycles does it raise the core reset. One machine cycle is twelve oscillator periods, so this takes 24 clocks. Any low sample throws the partial count away. The core reset then holds for as long as the qualified level stays high and drops on the first clock that sees the pin low.

A timeout pulse from a watchdog counter elsewhere on the chip also resets the core, starting with the clock that samples the pulse. The same pulse opens a window of 98 oscillator periods. During that window the block can ask the pad to drive the reset pin high, so that other devices on the board see the reset as well. A single control bit blocks this pin drive. The bit sits in an auxiliary control register that software reaches through a small write port. The block clears the bit whenever the core is held in reset, so after any reset the pin drive is enabled.

Top module: `pin_reset_ctrl`

## Requirements
- R1: `core_rst` rises after the 24th consecutive rising clock edge that samples `pin_in` high, and not before.
- R2: Any clock edge that samples `pin_in` low restarts qualification, so a run of 23 highs followed by a low gives no reset. A fresh run of 24 highs is then required.
- R3: When no watchdog window is open, `core_rst` falls on the first clock edge that samples `pin_in` low.
- R4: A clock edge that samples `wdt_to` high asserts `core_rst` from that edge on, for 98 clock cycles. This happens whatever the control bit holds.
- R5: If the control bit is 0 at the edge that opens a watchdog window, `pin_drive` is high for exactly the 98 cycles of that window and low outside any window.
- R6: If the control bit is 1 at the edge that opens a watchdog window, `pin_drive` stays low for the whole window, while `core_rst` still follows R4.
- R7: A write with `reg_we` high and `reg_addr` equal to 8'h8E loads the control bit from `reg_wdata` bit 3, and `drive_off` reads it back after that edge. A write to any other address leaves `drive_off` unchanged.
- R8: `drive_off` is 0 after power-on reset. It is cleared on any edge where `core_rst` is high, and that clear takes priority over a write on the same edge.
- R9: A `wdt_to` pulse that arrives while a window is open reloads the window to a full 98 cycles from that edge. The pin-drive choice made when the window opened is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| pin_in | input | 1 | Sampled level of the reset pin |
| wdt_to | input | 1 | Watchdog timeout pulse |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register write address |
| reg_wdata | input | 8 | Register write data |
| core_rst | output | 1 | Internal reset to the core, active high |
| pin_drive | output | 1 | Request to drive the reset pin high |
| drive_off | output | 1 | Current value of the pin-drive disable bit |

## Verification
The bench targets several corner cases, and each one shows a specific kind of broken design:
- **Qualification boundary:** a run of exactly 23 highs broken by a low must give no reset. An off-by-one counter fires a cycle early, and one that does not restart on a low gives the reset too soon.
- **Window length:** the pin-drive window is counted cycle by cycle against 98. A design that reloads to the wrong value, or stops one cycle late, shows the wrong count.
- **Suppressed drive:** with the disable bit set, the core reset must still appear while the pin drive stays low.
- **Bit timing:** because the reset clears the disable bit, a design that reads the bit live rather than at the edge that opens the window would wrongly drive the pin.
- **Retriggers:** a second timeout inside an open window, and writes while reset is active or aimed at a neighbouring address, show any wrong reload or any write that should have been ignored.

// File: rtl/pin_reset_pkg.sv
package pin_reset_pkg;

  function automatic int unsigned qual_cycles(input int unsigned per_mc, input int unsigned mcs);
    return per_mc * mcs;
  endfunction

  // saturating run-length of consecutive high samples
  function automatic int unsigned run_next(input int unsigned run, input logic lvl,
                                           input int unsigned lim);
    if (!lvl) return 0;
    if (run >= lim) return lim;
    return run + 1;
  endfunction

  // countdown window that a fire pulse reloads
  function automatic int unsigned window_next(input int unsigned left, input logic fire,
                                              input int unsigned len);
    if (fire) return len;
    if (left == 0) return 0;
    return left - 1;
  endfunction

endpackage

// File: rtl/rstq_pin_filter.sv
module rstq_pin_filter #(
  parameter int unsigned QUAL_CYC = 24
) (
  input  logic clk,
  input  logic por_n,
  input  logic pin_lvl,
  output logic qualified,
  output logic restart
);
  localparam int unsigned W = $clog2(QUAL_CYC + 1);

  logic [W-1:0] run_q;
  logic [W-1:0] run_d;

  assign run_d = W'(pin_reset_pkg::run_next(32'(run_q), pin_lvl, QUAL_CYC));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) run_q <= '0;
    else        run_q <= run_d;
  end

  assign qualified = (32'(run_q) == QUAL_CYC);
  assign restart   = !pin_lvl && (run_q != '0);
endmodule

// File: rtl/rstq_drive_seq.sv
module rstq_drive_seq #(
  parameter int unsigned DRIVE_LEN = 98
) (
  input  logic clk,
  input  logic por_n,
  input  logic wd_fire,
  input  logic suppress,
  output logic active,
  output logic drive,
  output logic reload
);
  localparam int unsigned W = $clog2(DRIVE_LEN + 1);

  logic [W-1:0] left_q;
  logic [W-1:0] left_d;
  logic         pick_q;

  assign left_d = W'(pin_reset_pkg::window_next(32'(left_q), wd_fire, DRIVE_LEN));
  assign active = (left_q != '0);
  assign reload = wd_fire && active;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      left_q <= '0;
      pick_q <= 1'b0;
    end else begin
      left_q <= left_d;
      if (wd_fire && !active) pick_q <= !suppress;
    end
  end

  assign drive = active && pick_q;
endmodule

// File: rtl/rstq_ctl_reg.sv
module rstq_ctl_reg #(
  parameter int unsigned AW      = 8,
  parameter int unsigned DW      = 8,
  parameter logic [AW-1:0] ADDR  = 8'h8E,
  parameter int unsigned OFF_BIT = 3
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          clr,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          bit_q,
  output logic          wr_hit
);
  logic unused_wdata;

  assign wr_hit       = we && (addr == ADDR);
  assign unused_wdata = ^wdata;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)      bit_q <= 1'b0;
    else if (clr)    bit_q <= 1'b0;
    else if (wr_hit) bit_q <= wdata[OFF_BIT];
  end
endmodule

// File: rtl/pin_reset_ctrl.sv
module pin_reset_ctrl #(
  parameter int unsigned OSC_PER_MC = 12,
  parameter int unsigned QUAL_MC    = 2,
  parameter int unsigned DRIVE_LEN  = 98,
  parameter int unsigned AW         = 8,
  parameter int unsigned DW         = 8,
  parameter logic [AW-1:0] AUX_ADDR = 8'h8E,
  parameter int unsigned OFF_BIT    = 3
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          pin_in,
  input  logic          wdt_to,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic          core_rst,
  output logic          pin_drive,
  output logic          drive_off
);
  localparam int unsigned QUAL_CYC = pin_reset_pkg::qual_cycles(OSC_PER_MC, QUAL_MC);

  logic qualified;
  logic qual_restart;
  logic wd_active;
  logic wd_reload;
  logic wr_hit;

  rstq_pin_filter #(.QUAL_CYC(QUAL_CYC)) u_filter (
    .clk(clk), .por_n(por_n), .pin_lvl(pin_in),
    .qualified(qualified), .restart(qual_restart)
  );

  generate
    if (DRIVE_LEN > 0) begin : g_seq
      rstq_drive_seq #(.DRIVE_LEN(DRIVE_LEN)) u_seq (
        .clk(clk), .por_n(por_n), .wd_fire(wdt_to), .suppress(drive_off),
        .active(wd_active), .drive(pin_drive), .reload(wd_reload)
      );
    end else begin : g_noseq
      assign wd_active = 1'b0;
      assign pin_drive = 1'b0;
      assign wd_reload = 1'b0;
    end
  endgenerate

  assign core_rst = qualified || wd_active;

  rstq_ctl_reg #(.AW(AW), .DW(DW), .ADDR(AUX_ADDR), .OFF_BIT(OFF_BIT)) u_reg (
    .clk(clk), .por_n(por_n), .clr(core_rst), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .bit_q(drive_off), .wr_hit(wr_hit)
  );
endmodule

// File: rtl/rstq_chk.sv
module rstq_chk #(
  parameter int unsigned AW         = 8,
  parameter int unsigned DW         = 8,
  parameter int unsigned DRIVE_LEN  = 98,
  parameter logic [AW-1:0] AUX_ADDR = 8'h8E,
  parameter int unsigned OFF_BIT    = 3
) (
  input logic          clk,
  input logic          por_n,
  input logic          pin_in,
  input logic          wdt_to,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr,
  input logic [DW-1:0] reg_wdata,
  input logic          core_rst,
  input logic          pin_drive,
  input logic          drive_off,
  input logic          qualified,
  input logic          wd_active
);
  int unsigned drv_run;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)         drv_run <= 0;
    else if (wdt_to)    drv_run <= 1;
    else if (pin_drive) drv_run <= drv_run + 1;
    else                drv_run <= 0;
  end

  AST_QUAL_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!por_n)
    $rose(qualified) |-> $past(pin_in)); // R1
  AST_LOW_DROPS_QUAL: assert property (@(posedge clk) disable iff (!por_n)
    !pin_in |=> !qualified); // R2
  AST_RELEASE_ON_LOW: assert property (@(posedge clk) disable iff (!por_n)
    (!pin_in && !wdt_to && !wd_active) |=> !core_rst); // R3
  AST_WD_IMMEDIATE: assert property (@(posedge clk) disable iff (!por_n)
    wdt_to |=> (core_rst && wd_active)); // R4
  AST_DRIVE_IN_RESET: assert property (@(posedge clk) disable iff (!por_n)
    pin_drive |-> core_rst); // R5
  AST_DRIVE_MAX_LEN: assert property (@(posedge clk) disable iff (!por_n)
    pin_drive |-> (drv_run <= DRIVE_LEN)); // R5
  AST_SUPPRESSED: assert property (@(posedge clk) disable iff (!por_n)
    (wdt_to && !wd_active && drive_off) |=> !pin_drive); // R6
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!por_n)
    (reg_we && reg_addr == AUX_ADDR && !core_rst) |=> (drive_off == $past(reg_wdata[OFF_BIT]))); // R7
  AST_CLEAR_IN_RESET: assert property (@(posedge clk) disable iff (!por_n)
    core_rst |=> !drive_off); // R8
  AST_RELOAD_KEEPS_PICK: assert property (@(posedge clk) disable iff (!por_n)
    (wdt_to && wd_active) |=> (pin_drive == $past(pin_drive))); // R9
endmodule

bind pin_reset_ctrl rstq_chk #(
  .AW(AW), .DW(DW), .DRIVE_LEN(DRIVE_LEN), .AUX_ADDR(AUX_ADDR), .OFF_BIT(OFF_BIT)
) u_chk (
  .clk(clk), .por_n(por_n), .pin_in(pin_in), .wdt_to(wdt_to), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .core_rst(core_rst),
  .pin_drive(pin_drive), .drive_off(drive_off), .qualified(qualified),
  .wd_active(wd_active)
);

// File: tb/pin_reset_ctrl_tb.sv
`timescale 1ns/100ps
module pin_reset_ctrl_tb;
  localparam int HOLD = 24;
  localparam int WIN  = 98;
  localparam logic [7:0] REG_AT = 8'h8E;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic pin_in = 1'b0, wdt_to = 1'b0, reg_we = 1'b0;
  logic [7:0] reg_addr = '0, reg_wdata = '0;
  logic core_rst, pin_drive, drive_off;

  int vectors = 0;
  int errors = 0;
  int hi_seen = 0, win_left = 0;
  bit will_drive = 0, off_bit = 0;

  always #2.5 clk = ~clk;

  pin_reset_ctrl u_dut (
    .clk(clk), .por_n(por_n), .pin_in(pin_in), .wdt_to(wdt_to), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .core_rst(core_rst),
    .pin_drive(pin_drive), .drive_off(drive_off)
  );

  function automatic int after_sample(int seen, bit lvl);
    int r;
    r = lvl ? seen + 1 : 0;
    return (r > HOLD) ? HOLD : r;
  endfunction

  function automatic bit exp_rst();
    return (hi_seen == HOLD) || (win_left != 0);
  endfunction

  task automatic check(input string tag, input bit ok, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input bit p, input bit w, input bit we, input logic [7:0] a,
                      input logic [7:0] d, input string tag);
    bit rst_before;
    pin_in = p; wdt_to = w; reg_we = we; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    rst_before = exp_rst();
    if (rst_before) off_bit = 0;
    else if (we && a == REG_AT) off_bit = d[3];
    if (w) begin
      if (win_left == 0) will_drive = !off_bit_prev;
      win_left = WIN;
    end else if (win_left > 0) win_left--;
    hi_seen = after_sample(hi_seen, p);
    off_bit_prev = off_bit;
    vectors++;
    if (core_rst !== exp_rst() || pin_drive !== (win_left != 0 && will_drive) ||
        drive_off !== off_bit) begin
      errors++;
      $display("FAIL %s rst/drive/off actual=%0b%0b%0b expected=%0b%0b%0b", tag,
               core_rst, pin_drive, drive_off, exp_rst(), (win_left != 0 && will_drive), off_bit);
    end
  endtask

  bit off_bit_prev = 0;

  task automatic idle(input int n, input bit p, input string tag);
    for (int i = 0; i < n; i++) step(p, 0, 0, 8'h00, 8'h00, tag);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", vectors, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    int drv_cnt, rst_cnt;
    bit lvl;
    int run;
    void'($urandom(32'h0051_5eed));
    repeat (3) @(posedge clk);
    #1;
    check("R8 reset rst", core_rst === 1'b0, core_rst, 0);
    check("R8 reset off", drive_off === 1'b0, drive_off, 0);
    check("R5 reset drive", pin_drive === 1'b0, pin_drive, 0);
    por_n = 1'b1;

    // R7: write lands, neighbour address ignored
    step(0, 0, 1, REG_AT, 8'h08, "R7");
    check("R7 set", drive_off === 1'b1, drive_off, 1);
    step(0, 0, 1, 8'h8F, 8'h00, "R7");
    check("R7 other addr", drive_off === 1'b1, drive_off, 1);
    step(0, 0, 1, REG_AT, 8'hF7, "R7");
    check("R7 clear", drive_off === 1'b0, drive_off, 0);

    // R2: 23 highs then low
    idle(23, 1, "R2");
    step(0, 0, 0, 8'h00, 8'h00, "R2");
    check("R2 no reset", core_rst === 1'b0, core_rst, 0);
    // R1: 24 highs
    step(0, 0, 1, REG_AT, 8'h08, "R1");
    idle(23, 1, "R1");
    check("R1 before 24", core_rst === 1'b0, core_rst, 0);
    idle(1, 1, "R1");
    check("R1 at 24", core_rst === 1'b1, core_rst, 1);
    // R8: bit cleared while in reset, write ignored
    step(1, 0, 1, REG_AT, 8'h08, "R8");
    check("R8 cleared", drive_off === 1'b0, drive_off, 0);
    idle(5, 1, "R8");
    // R3: release on first low
    step(0, 0, 0, 8'h00, 8'h00, "R3");
    check("R3 release", core_rst === 1'b0, core_rst, 0);

    // R5: drive window with bit clear
    drv_cnt = 0; rst_cnt = 0;
    step(0, 1, 0, 8'h00, 8'h00, "R4");
    check("R4 immediate", core_rst === 1'b1, core_rst, 1);
    drv_cnt += pin_drive; rst_cnt += core_rst;
    for (int i = 0; i < 110; i++) begin
      step(0, 0, 0, 8'h00, 8'h00, "R5");
      drv_cnt += pin_drive; rst_cnt += core_rst;
    end
    check("R5 drive length", drv_cnt == WIN, drv_cnt, WIN);
    check("R4 reset length", rst_cnt == WIN, rst_cnt, WIN);

    // R6: bit set, drive suppressed
    step(0, 0, 1, REG_AT, 8'h08, "R6");
    drv_cnt = 0; rst_cnt = 0;
    for (int i = 0; i < 110; i++) begin
      step(0, (i == 0), 0, 8'h00, 8'h00, "R6");
      drv_cnt += pin_drive; rst_cnt += core_rst;
    end
    check("R6 no drive", drv_cnt == 0, drv_cnt, 0);
    check("R6 reset still", rst_cnt == WIN, rst_cnt, WIN);

    // R9: retrigger inside window
    drv_cnt = 0;
    for (int i = 0; i < 200; i++) begin
      step(0, (i == 0 || i == 50), 0, 8'h00, 8'h00, "R9");
      drv_cnt += pin_drive;
    end
    check("R9 reload length", drv_cnt == 50 + WIN, drv_cnt, 50 + WIN);

    // constrained random mix
    lvl = 0; run = 0;
    for (int i = 0; i < 4000; i++) begin
      bit w, we;
      logic [7:0] a;
      if (run == 0) begin
        lvl = ($urandom % 3) != 0;
        run = 1 + ($urandom % 40);
      end
      run--;
      w  = ($urandom % 200) == 0;
      we = ($urandom % 8) == 0;
      a  = ($urandom % 2) ? REG_AT : 8'($urandom);
      step(lvl, w, we, a, 8'($urandom), "R2 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule